// File: doc/BRIEF.md
# Half-Duplex Debug Data Mailbox

A 64-bit mailbox that a processor and an external debugger use to pass data through one system register. Inside are two 32-bit words, one for each direction. The receive word carries data from the debugger to the processor. The transmit word carries data from the processor to the debugger. Each word has its own full flag. The processor reaches both words with a single 64-bit access, and a fixed system-register encoding selects that access. A 64-bit access maps the two halves in opposite directions for write and for read. A write loads the high half into the receive word and the low half into the transmit word. A read returns the transmit word in the high half and the receive word in the low half.

The debugger has two 32-bit streams. An inbound valid/ready stream fills the receive word, and it asserts ready only while the receive word is empty. An outbound valid/ready stream offers the transmit word while it is full, and a completed handshake drains it. Both full flags are also brought out as plain status pins.

When the processor and the debugger touch the same state in one cycle, the processor update is applied first and the debugger update is applied on top of it.

Top module: `dbg_mailbox`

## Requirements
- R1: After reset both data words are zero, both full flags are 0, `cpu_rvalid` is 0 and `dbg_rx_ready` is 1.
- R2: A selected processor write loads `cpu_wdata[63:32]` into the receive word and `cpu_wdata[31:0]` into the transmit word.
- R3: A selected processor write sets the transmit-full flag to 1 and leaves the receive-full flag as it was.
- R4: A selected processor read drives `cpu_rvalid` high for exactly the next cycle. In that cycle `cpu_rdata` holds the transmit word in [63:32] and the receive word in [31:0], as they stood when the read was issued.
- R5: A selected processor read clears the receive-full flag on the following clock edge.
- R6: An access is selected only when `cpu_enc` equals 16'h9820. That value packs op0=2'b10 in [15:14], op1=3'b011 in [13:11], CRn=4'b0000 in [10:7], CRm=4'b0100 in [6:3] and op2=3'b000 in [2:0]. Any other encoding changes no word and no flag, and it raises no `cpu_rvalid`.
- R7: `dbg_rx_ready` equals the inverse of the receive-full flag. A handshake loads `dbg_rx_data` into the receive word and sets receive-full. Inbound data offered while the receive word is full is ignored.
- R8: `dbg_tx_valid` equals the transmit-full flag and `dbg_tx_data` is the transmit word. An outbound handshake clears transmit-full.
- R9: In a cycle where both sides act, the debugger update wins. A processor write together with an outbound handshake leaves transmit-full at 0 and the new transmit word in place. A processor write or read together with an inbound handshake leaves the debugger's data in the receive word and receive-full at 1.
- R10: A selected write and a selected read in the same cycle return the contents as they were before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| cpu_enc | input | 16 | Encoding of the processor's system-register access |
| cpu_wr | input | 1 | Processor write strobe |
| cpu_rd | input | 1 | Processor read strobe |
| cpu_wdata | input | 64 | Processor write data |
| cpu_rdata | output | 64 | Processor read data, one cycle after the read |
| cpu_rvalid | output | 1 | Marks `cpu_rdata` as valid |
| dbg_rx_valid | input | 1 | Debugger offers an inbound word |
| dbg_rx_ready | output | 1 | Receive word is empty and can take data |
| dbg_rx_data | input | 32 | Inbound word from the debugger |
| dbg_tx_valid | output | 1 | Transmit word is available |
| dbg_tx_ready | input | 1 | Debugger takes the transmit word |
| dbg_tx_data | output | 32 | Transmit word to the debugger |
| rx_full | output | 1 | Receive-full flag |
| tx_full | output | 1 | Transmit-full flag |

## Verification
Flag, word and ready/valid updates appear one clock edge after the stimulus. Read data and its valid strobe also come one edge after the read, and they show the contents from before that edge. The bench drives each stimulus on a falling edge and checks on the falling edge after the next rising edge. Every output is compared in each stepped cycle, so a one-cycle `cpu_rvalid` pulse that lingers into the next cycle is caught. The receive word has no direct output, so the bench confirms its value through a later selected read.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int ENC_W = 16;

  typedef struct packed {
    logic [1:0] op0;
    logic [2:0] op1;
    logic [3:0] crn;
    logic [3:0] crm;
    logic [2:0] op2;
  } sysreg_enc_t;

  localparam sysreg_enc_t MBX_ENC = '{op0: 2'b10, op1: 3'b011, crn: 4'b0000,
                                      crm: 4'b0100, op2: 3'b000};
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
  import mbx_pkg::*;
#(
  parameter sysreg_enc_t MATCH = MBX_ENC
) (
  input  sysreg_enc_t enc,
  input  logic        wr,
  input  logic        rd,
  output logic        wr_sel,
  output logic        rd_sel
);
  logic hit;

  always_comb begin
    hit = (enc.op0 == MATCH.op0) && (enc.op1 == MATCH.op1) &&
          (enc.crn == MATCH.crn) && (enc.crm == MATCH.crm) &&
          (enc.op2 == MATCH.op2);
    wr_sel = hit && wr;
    rd_sel = hit && rd;
  end
endmodule

// File: rtl/mbx_store.sv
module mbx_store #(
  parameter int WORD_W = 32,
  localparam int DATA_W = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_sel,
  input  logic              rd_sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  output logic              in_ready,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] rx_word,
  output logic [WORD_W-1:0] tx_word,
  output logic              rx_full,
  output logic              tx_full
);
  logic in_hs, out_hs;

  assign in_ready  = !rx_full;
  assign out_valid = tx_full;
  assign in_hs     = in_valid && in_ready;
  assign out_hs    = out_ready && out_valid;

  // Receive side: processor update first, debugger on top.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_word <= '0;
      rx_full <= 1'b0;
    end else begin
      if (wr_sel) rx_word <= wdata[DATA_W-1:WORD_W];
      if (rd_sel) rx_full <= 1'b0;
      if (in_hs) begin
        rx_word <= in_data;
        rx_full <= 1'b1;
      end
    end
  end

  // Transmit side: processor update first, debugger on top.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_word <= '0;
      tx_full <= 1'b0;
    end else begin
      if (wr_sel) begin
        tx_word <= wdata[WORD_W-1:0];
        tx_full <= 1'b1;
      end
      if (out_hs) tx_full <= 1'b0;
    end
  end

  a_r3_wr_sets_txfull: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sel && !out_ready |=> tx_full);
  a_r3_wr_keeps_rxfull: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sel && !rd_sel && !in_valid |=> rx_full == $past(rx_full));
  a_r5_rd_clears_rxfull: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sel && !in_valid |=> !rx_full);
  a_r7_in_loads: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !rx_full |=> rx_full && rx_word == $past(in_data));
  a_r7_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full && !wr_sel |=> $stable(rx_word));
  a_r8_out_drains: assert property (@(posedge clk) disable iff (!rst_n)
    out_ready && tx_full |=> !tx_full);
  a_r9_wr_loses_flag: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sel && out_ready && tx_full |=> !tx_full && tx_word == $past(wdata[WORD_W-1:0]));
endmodule

// File: rtl/mbx_rdport.sv
module mbx_rdport #(
  parameter int WORD_W = 32,
  localparam int DATA_W = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_sel,
  input  logic [WORD_W-1:0] tx_word,
  input  logic [WORD_W-1:0] rx_word,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_sel;
      if (rd_sel) rdata <= {tx_word, rx_word};
    end
  end

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_sel |=> !rvalid);
  a_r4_data_held: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_sel |=> $stable(rdata));
endmodule

// File: rtl/dbg_mailbox.sv
module dbg_mailbox
  import mbx_pkg::*;
#(
  parameter int WORD_W = 32,
  localparam int DATA_W = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ENC_W-1:0]  cpu_enc,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_rvalid,
  input  logic              dbg_rx_valid,
  output logic              dbg_rx_ready,
  input  logic [WORD_W-1:0] dbg_rx_data,
  output logic              dbg_tx_valid,
  input  logic              dbg_tx_ready,
  output logic [WORD_W-1:0] dbg_tx_data,
  output logic              rx_full,
  output logic              tx_full
);
  logic              wr_sel, rd_sel;
  logic [WORD_W-1:0] rx_word, tx_word;
  sysreg_enc_t       enc_s;

  assign enc_s = sysreg_enc_t'(cpu_enc);

  mbx_decode #(.MATCH(MBX_ENC)) u_decode (
    .enc(enc_s), .wr(cpu_wr), .rd(cpu_rd), .wr_sel(wr_sel), .rd_sel(rd_sel)
  );

  mbx_store #(.WORD_W(WORD_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_sel(wr_sel), .rd_sel(rd_sel), .wdata(cpu_wdata),
    .in_valid(dbg_rx_valid), .in_data(dbg_rx_data), .in_ready(dbg_rx_ready),
    .out_ready(dbg_tx_ready), .out_valid(dbg_tx_valid),
    .rx_word(rx_word), .tx_word(tx_word), .rx_full(rx_full), .tx_full(tx_full)
  );

  mbx_rdport #(.WORD_W(WORD_W)) u_rdport (
    .clk(clk), .rst_n(rst_n), .rd_sel(rd_sel), .tx_word(tx_word), .rx_word(rx_word),
    .rdata(cpu_rdata), .rvalid(cpu_rvalid)
  );

  assign dbg_tx_data = tx_word;

  a_r6_foreign_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_enc != ENC_W'(MBX_ENC) |=> !cpu_rvalid);
  a_r6_foreign_no_tx: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_enc != ENC_W'(MBX_ENC) && !dbg_tx_ready |=> $stable(dbg_tx_data) && $stable(tx_full));
  a_r4_read_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rd && cpu_enc == ENC_W'(MBX_ENC) |=> cpu_rvalid);
  a_r2_low_to_tx: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr && cpu_enc == ENC_W'(MBX_ENC) |=> dbg_tx_data == $past(cpu_wdata[WORD_W-1:0]));
endmodule

// File: tb/test_dbg_mailbox.sv
module test_dbg_mailbox;
  localparam logic [15:0] SEL = 16'h9820;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_enc = '0;
  logic        cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [63:0] cpu_wdata = '0;
  logic [63:0] cpu_rdata;
  logic        cpu_rvalid;
  logic        dbg_rx_valid = 1'b0;
  logic        dbg_rx_ready;
  logic [31:0] dbg_rx_data = '0;
  logic        dbg_tx_valid;
  logic        dbg_tx_ready = 1'b0;
  logic [31:0] dbg_tx_data;
  logic        rx_full, tx_full;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [31:0] m_rx = '0, m_tx = '0;
  logic        m_rxf = 1'b0, m_txf = 1'b0;
  logic [31:0] lfsr = 32'h1234_5678;

  dbg_mailbox i_dbg_mailbox (
    .clk(clk), .rst_n(rst_n), .cpu_enc(cpu_enc), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid),
    .dbg_rx_valid(dbg_rx_valid), .dbg_rx_ready(dbg_rx_ready), .dbg_rx_data(dbg_rx_data),
    .dbg_tx_valid(dbg_tx_valid), .dbg_tx_ready(dbg_tx_ready), .dbg_tx_data(dbg_tx_data),
    .rx_full(rx_full), .tx_full(tx_full)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      errors++;
      $display("FAIL watchdog act=%0d exp<190000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  // One cycle: drive at falling edge, check at the next falling edge.
  task automatic step(string tag, logic [15:0] enc, logic wr, logic rd, logic [63:0] wd,
                      logic rxv, logic [31:0] rxd, logic txr);
    logic        sel, in_hs, out_hs, exp_rv;
    logic [63:0] exp_rd;
    sel    = (enc == SEL);
    in_hs  = rxv && !m_rxf;
    out_hs = txr && m_txf;
    exp_rv = sel && rd;
    exp_rd = {m_tx, m_rx};
    if (sel && wr) begin m_rx = wd[63:32]; m_tx = wd[31:0]; m_txf = 1'b1; end
    if (sel && rd) m_rxf = 1'b0;
    if (in_hs) begin m_rx = rxd; m_rxf = 1'b1; end
    if (out_hs) m_txf = 1'b0;
    cpu_enc = enc; cpu_wr = wr; cpu_rd = rd; cpu_wdata = wd;
    dbg_rx_valid = rxv; dbg_rx_data = rxd; dbg_tx_ready = txr;
    @(posedge clk);
    @(negedge clk);
    chk(tag, "rvalid", 64'(cpu_rvalid), 64'(exp_rv));
    if (exp_rv) chk(tag, "rdata", cpu_rdata, exp_rd);
    chk(tag, "rx_full", 64'(rx_full), 64'(m_rxf));
    chk(tag, "tx_full", 64'(tx_full), 64'(m_txf));
    chk(tag, "tx_data", 64'(dbg_tx_data), 64'(m_tx));
    chk(tag, "rx_ready", 64'(dbg_rx_ready), 64'(!m_rxf));
    chk(tag, "tx_valid", 64'(dbg_tx_valid), 64'(m_txf));
  endtask

  task automatic idle(string tag);
    step(tag, 16'h0000, 1'b0, 1'b0, 64'h0, 1'b0, 32'h0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk("R1", "rvalid", 64'(cpu_rvalid), 64'h0);
    chk("R1", "rx_full", 64'(rx_full), 64'h0);
    chk("R1", "tx_full", 64'(tx_full), 64'h0);
    chk("R1", "tx_data", 64'(dbg_tx_data), 64'h0);
    chk("R1", "rx_ready", 64'(dbg_rx_ready), 64'h1);
    step("R1", SEL, 1'b0, 1'b1, 64'h0, 1'b0, 32'h0, 1'b0);
    idle("R4");
    // R2/R3: write splits halves and sets only tx_full
    step("R2", SEL, 1'b1, 1'b0, 64'h1111_2222_3333_4444, 1'b0, 32'h0, 1'b0);
    step("R4", SEL, 1'b0, 1'b1, 64'h0, 1'b0, 32'h0, 1'b0);
    idle("R4");
    // R7: inbound handshake, then ignored while full
    step("R7", 16'h0000, 1'b0, 1'b0, 64'h0, 1'b1, 32'hA5A5_0001, 1'b0);
    step("R7", 16'h0000, 1'b0, 1'b0, 64'h0, 1'b1, 32'hDEAD_BEEF, 1'b0);
    // R3: write while rx_full keeps it set
    step("R3", SEL, 1'b1, 1'b0, 64'hCAFE_0000_0000_BEEF, 1'b0, 32'h0, 1'b0);
    // R5: read clears rx_full
    step("R5", SEL, 1'b0, 1'b1, 64'h0, 1'b0, 32'h0, 1'b0);
    // R8: outbound handshake drains
    step("R8", 16'h0000, 1'b0, 1'b0, 64'h0, 1'b0, 32'h0, 1'b1);
    step("R8", 16'h0000, 1'b0, 1'b0, 64'h0, 1'b0, 32'h0, 1'b1);
    // R9: same-cycle collisions
    step("R9", SEL, 1'b1, 1'b0, 64'h0101_0101_0202_0202, 1'b0, 32'h0, 1'b0);
    step("R9", SEL, 1'b1, 1'b0, 64'h0303_0303_0404_0404, 1'b1, 32'h7777_7777, 1'b1);
    step("R9", SEL, 1'b0, 1'b1, 64'h0, 1'b0, 32'h0, 1'b0);
    step("R9", SEL, 1'b0, 1'b1, 64'h0, 1'b1, 32'h8888_8888, 1'b0);
    step("R9", SEL, 1'b0, 1'b1, 64'h0, 1'b0, 32'h0, 1'b0);
    // R10: write and read together return old contents
    step("R10", SEL, 1'b1, 1'b1, 64'h5555_6666_7777_8888, 1'b0, 32'h0, 1'b0);
    step("R10", SEL, 1'b0, 1'b1, 64'h0, 1'b0, 32'h0, 1'b0);
    // R6: sweep every foreign encoding with write and read, rx_full set
    step("R6", 16'h0000, 1'b0, 1'b0, 64'h0, 1'b1, 32'h0BAD_F00D, 1'b0);
    for (int i = 0; i < 65536; i++) begin
      if (i[15:0] != SEL)
        step("R6", 16'(i), 1'b1, 1'b1, {16'(i), 16'hFFFF ^ 16'(i), 32'(i) * 32'd2654435761},
             1'b0, 32'h0, 1'b0);
    end
    step("R6", SEL, 1'b0, 1'b1, 64'h0, 1'b0, 32'h0, 1'b0);
    // Mixed pseudo-random traffic: all interactions against the model (R9)
    for (int k = 0; k < 4000; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      step("R9", lfsr[3:0] == 4'h0 ? lfsr[31:16] : SEL, lfsr[4], lfsr[5],
           {lfsr, ~lfsr}, lfsr[6], lfsr ^ 32'h3C3C_3C3C, lfsr[7]);
    end
    idle("R4");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule